// File: doc/BRIEF.md
# Panel Register Init Sequencer

This block programs an external display controller over a three-wire, write-only serial link. It holds a small constant table of register writes. Each table entry has a 16-bit register index, a 16-bit value and a wait time in microseconds that applies after the write.

Every entry goes out as two 24-bit frames. The first frame carries a fixed index tag and the register index. The second carries a fixed data tag and the value. After the data frame, the block waits for the entry's delay before it moves to the next entry.

Three start inputs pick which run to play: power-up, panel enable or panel disable. The power-up run continues straight into the panel-enable entries without a second request. A microsecond time base comes from the system clock through a parameterised prescaler. The serial clock half-period and the end-of-frame hold time are also parameters.

Top module: `panel_init_seq`

## Requirements
- R1: Each frame is 24 bits, sent most significant bit first. An index frame has 0x74 in bits 23:16 and the register index in bits 15:0. A data frame has 0x76 in bits 23:16 and the value in bits 15:0. Every entry sends its index frame first and its data frame second.
- R2: Inside a frame, each bit puts `spi_sclk` low for SCLK_HALF cycles and then high for SCLK_HALF cycles. `spi_sdo` changes only while `spi_sclk` is low, and the receiver reads it on the rising edge.
- R3: When idle, `spi_cs_n`, `spi_sclk` and `spi_sdo` are all high. For each frame, `spi_cs_n` is low for exactly 48*SCLK_HALF + GAP_US*CLK_PER_US cycles. After the 24th rising edge, `spi_sclk` stays high until `spi_cs_n` rises.
- R4: Between the two frames of one entry, `spi_cs_n` is high for exactly 2 cycles. Between the data frame of an entry with delay d µs and the next index frame, `spi_cs_n` is high for exactly 2 + d*CLK_PER_US cycles.
- R5: `start_on` plays these entries (index, value, delay µs) in order: (0x07, 0x0001, 150), (0x07, 0x0101, 150), (0x07, 0x0103, 0).
- R6: `start_off` plays these entries in order: (0x0B, 0x33E1, 0), (0x07, 0x0102, 150), (0x07, 0x0100, 150), (0x12, 0x0000, 0), (0x10, 0x0000, 0).
- R7: `start_pwr` plays (0x11, 0x2000, 0), (0x13, 0x4000, 5), (0x10, 0x3100, 20), (0x08, 0x0005, 0). It then plays the R5 entries with no further request and gives a single `done` at the end.
- R8: A start request that arrives while `busy` is high is ignored: it produces no extra frame and no extra `done`.
- R9: `busy` goes high in the cycle after an accepted start and stays high until the run ends. `done` is high for exactly one cycle, the first cycle in which `busy` is low again.
- R10: If several starts are high in the same idle cycle, power-up wins over panel enable, and panel enable wins over panel disable.
- R11: During and just after reset, `spi_cs_n`, `spi_sclk` and `spi_sdo` are 1, and `busy` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_pwr | input | 1 | Request the power-up run, which continues into panel enable |
| start_on | input | 1 | Request the panel-enable run |
| start_off | input | 1 | Request the panel-disable run |
| spi_cs_n | output | 1 | Serial chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_sdo | output | 1 | Serial data to the panel |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |

## Verification
The bench builds the block with CLK_PER_US=4, SCLK_HALF=2 and GAP_US=3. With these values a 150 µs wait lasts 600 cycles and one frame holds chip select low for 108 cycles, so every run finishes within a few thousand cycles. Because the counts are small, the exact frame width, the half-period of each bit and every inter-frame gap can be compared cycle by cycle against the formulas in R3 and R4. The fall-through from power-up into panel enable, start requests made during a run, and simultaneous starts are also exercised at this scale.

// File: rtl/panel_seq_pkg.sv
// Shared widths, frame tags, table layout and state types for the panel
// register init sequencer. Assumes the table fits in ADDR_W address bits.
package panel_seq_pkg;
    localparam int FRAME_W = 24;
    localparam int REG_W   = 16;
    localparam int DLY_W   = 10;
    localparam int ADDR_W  = 4;

    localparam logic [7:0] IDX_TAG = 8'h74;
    localparam logic [7:0] DAT_TAG = 8'h76;

    // Table layout: the power-up entries sit directly before the panel-enable
    // entries, so a power-up run falls through into panel enable.
    localparam logic [ADDR_W-1:0] PWR_FIRST = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ON_FIRST  = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] ON_LAST   = ADDR_W'(6);
    localparam logic [ADDR_W-1:0] OFF_FIRST = ADDR_W'(7);
    localparam logic [ADDR_W-1:0] OFF_LAST  = ADDR_W'(11);

    typedef struct packed {
        logic [REG_W-1:0] idx;
        logic [REG_W-1:0] val;
        logic [DLY_W-1:0] dly;
    } seq_entry_t;

    typedef enum logic [2:0] {
        C_IDLE, C_IDX_GO, C_IDX_WAIT, C_DAT_GO, C_DAT_WAIT, C_DELAY
    } ctl_state_t;

    typedef enum logic [1:0] {
        S_IDLE, S_SHIFT, S_HOLD
    } shf_state_t;
endpackage

// File: rtl/usec_timer.sv
// Restartable microsecond timer. A start pulse loads count_us and restarts
// the prescaler. expire is high for one cycle, exactly count_us*CLK_PER_US
// cycles after the start edge.
// Assumes count_us is nonzero when started; a zero count never expires.
module usec_timer #(
    parameter int CLK_PER_US = 100,
    parameter int CNT_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count_us,
    output logic             expire
);
    localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_US - 1);

    logic             run;
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] rem;

    assign expire = run && (pre == PRE_LAST) && (rem == CNT_W'(1));

    // Count prescaler cycles; step the remaining microseconds on each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            pre <= '0;
            rem <= '0;
        end else if (start) begin
            run <= (count_us != '0);
            pre <= '0;
            rem <= count_us;
        end else if (run) begin
            if (pre == PRE_LAST) begin
                pre <= '0;
                if (rem == CNT_W'(1)) run <= 1'b0;
                else                  rem <= rem - CNT_W'(1);
            end else begin
                pre <= pre + PRE_W'(1);
            end
        end
    end
endmodule

// File: rtl/seq_rom.sv
// Constant table of register writes: index, value and post-write delay in µs.
// Addresses past the last entry read as zero.
module seq_rom
    import panel_seq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output seq_entry_t        entry
);
    function automatic seq_entry_t mk(input logic [15:0] i, input logic [15:0] v,
                                      input int d);
        seq_entry_t e;
        e.idx = i;
        e.val = v;
        e.dly = DLY_W'(d);
        return e;
    endfunction

    // Decode the address into one table entry.
    always_comb begin
        case (addr)
            4'd0:    entry = mk(16'h0011, 16'h2000, 0);
            4'd1:    entry = mk(16'h0013, 16'h4000, 5);
            4'd2:    entry = mk(16'h0010, 16'h3100, 20);
            4'd3:    entry = mk(16'h0008, 16'h0005, 0);
            4'd4:    entry = mk(16'h0007, 16'h0001, 150);
            4'd5:    entry = mk(16'h0007, 16'h0101, 150);
            4'd6:    entry = mk(16'h0007, 16'h0103, 0);
            4'd7:    entry = mk(16'h000B, 16'h33E1, 0);
            4'd8:    entry = mk(16'h0007, 16'h0102, 150);
            4'd9:    entry = mk(16'h0007, 16'h0100, 150);
            4'd10:   entry = mk(16'h0012, 16'h0000, 0);
            4'd11:   entry = mk(16'h0010, 16'h0000, 0);
            default: entry = mk(16'h0000, 16'h0000, 0);
        endcase
    end
endmodule

// File: rtl/spi_frame_tx.sv
// Sends one 24-bit frame MSB first on a write-only three-wire link.
// The clock idles high; each bit has a low phase and then a high phase of
// SCLK_HALF cycles each. After the last bit, chip select stays low for
// GAP_US microseconds, then all lines return high and done pulses once.
// Assumes start arrives only while idle, and GAP_US >= 1.
module spi_frame_tx
    import panel_seq_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int SCLK_HALF  = 10,
    parameter int GAP_US     = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    output logic               cs_n,
    output logic               sclk,
    output logic               sdo,
    output logic               done
);
    localparam int HC_W  = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int BIT_W = $clog2(FRAME_W);
    localparam int GAP_W = $clog2(GAP_US + 1);
    localparam logic [HC_W-1:0] HC_LAST = HC_W'(SCLK_HALF - 1);

    shf_state_t         state;
    logic               phase;
    logic [HC_W-1:0]    hcnt;
    logic [BIT_W-1:0]   bitn;
    logic [FRAME_W-1:0] sreg;
    logic               done_q;
    logic               gap_go;
    logic               gap_end;

    assign gap_go = (state == S_SHIFT) && (hcnt == HC_LAST) && phase && (bitn == '0);

    usec_timer #(.CLK_PER_US(CLK_PER_US), .CNT_W(GAP_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (gap_go),
        .count_us (GAP_W'(GAP_US)),
        .expire   (gap_end)
    );

    assign cs_n = (state == S_IDLE);
    assign sclk = !((state == S_SHIFT) && !phase);
    assign sdo  = (state == S_IDLE) ? 1'b1 : sreg[FRAME_W-1];
    assign done = done_q;

    // Frame state machine: shift the bits, then hold chip select low for the gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            phase  <= 1'b0;
            hcnt   <= '0;
            bitn   <= '0;
            sreg   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        state <= S_SHIFT;
                        phase <= 1'b0;
                        hcnt  <= '0;
                        bitn  <= BIT_W'(FRAME_W - 1);
                        sreg  <= frame;
                    end
                end
                S_SHIFT: begin
                    if (hcnt == HC_LAST) begin
                        hcnt <= '0;
                        if (!phase) begin
                            phase <= 1'b1;
                        end else if (bitn == '0) begin
                            state <= S_HOLD;
                        end else begin
                            bitn  <= bitn - BIT_W'(1);
                            sreg  <= {sreg[FRAME_W-2:0], 1'b0};
                            phase <= 1'b0;
                        end
                    end else begin
                        hcnt <= hcnt + HC_W'(1);
                    end
                end
                S_HOLD: begin
                    if (gap_end) begin
                        state  <= S_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/panel_init_seq.sv
// Top of the panel register init sequencer. A start request picks a range
// of the table. Each entry is sent as an index frame and then a data frame,
// followed by the entry's microsecond delay when it is nonzero.
// busy covers the whole run and done pulses once at its end.
// Assumes the start inputs are synchronous to clk.
module panel_init_seq
    import panel_seq_pkg::*;
#(
    parameter int CLK_PER_US = 100,
    parameter int SCLK_HALF  = 10,
    parameter int GAP_US     = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_pwr,
    input  logic start_on,
    input  logic start_off,
    output logic spi_cs_n,
    output logic spi_sclk,
    output logic spi_sdo,
    output logic busy,
    output logic done
);
    ctl_state_t         st;
    logic [ADDR_W-1:0]  ptr;
    logic [ADDR_W-1:0]  last_addr;
    logic               done_q;
    seq_entry_t         entry;
    logic [FRAME_W-1:0] frame_sel;
    logic               tx_start;
    logic               tx_done;
    logic               dly_go;
    logic               dly_end;
    logic               advance;

    seq_rom u_rom (
        .addr  (ptr),
        .entry (entry)
    );

    assign frame_sel = (st == C_IDX_GO) ? {IDX_TAG, entry.idx} : {DAT_TAG, entry.val};
    assign tx_start  = (st == C_IDX_GO) || (st == C_DAT_GO);

    spi_frame_tx #(
        .CLK_PER_US (CLK_PER_US),
        .SCLK_HALF  (SCLK_HALF),
        .GAP_US     (GAP_US)
    ) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tx_start),
        .frame (frame_sel),
        .cs_n  (spi_cs_n),
        .sclk  (spi_sclk),
        .sdo   (spi_sdo),
        .done  (tx_done)
    );

    assign dly_go  = (st == C_DAT_WAIT) && tx_done && (entry.dly != '0);
    assign advance = ((st == C_DAT_WAIT) && tx_done && (entry.dly == '0)) ||
                     ((st == C_DELAY) && dly_end);

    usec_timer #(.CLK_PER_US(CLK_PER_US), .CNT_W(DLY_W)) u_dly (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (dly_go),
        .count_us (entry.dly),
        .expire   (dly_end)
    );

    assign busy = (st != C_IDLE);
    assign done = done_q;

    // Run controller: choose a range, step through entries, wait out delays.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= C_IDLE;
            ptr       <= '0;
            last_addr <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                C_IDLE: begin
                    if (start_pwr) begin
                        ptr <= PWR_FIRST; last_addr <= ON_LAST;  st <= C_IDX_GO;
                    end else if (start_on) begin
                        ptr <= ON_FIRST;  last_addr <= ON_LAST;  st <= C_IDX_GO;
                    end else if (start_off) begin
                        ptr <= OFF_FIRST; last_addr <= OFF_LAST; st <= C_IDX_GO;
                    end
                end
                C_IDX_GO:   st <= C_IDX_WAIT;
                C_IDX_WAIT: if (tx_done) st <= C_DAT_GO;
                C_DAT_GO:   st <= C_DAT_WAIT;
                C_DAT_WAIT: if (dly_go) st <= C_DELAY;
                C_DELAY:    ;
                default:    st <= C_IDLE;
            endcase
            if (advance) begin
                if (ptr == last_addr) begin
                    st     <= C_IDLE;
                    done_q <= 1'b1;
                end else begin
                    ptr <= ptr + ADDR_W'(1);
                    st  <= C_IDX_GO;
                end
            end
        end
    end
endmodule

// File: rtl/panel_init_seq_chk.sv
// Property checker for panel_init_seq, attached through bind below.
module panel_init_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_sdo,
    input logic busy,
    input logic done
);
    // R2: data moves only while the clock is low inside a frame
    a_r2_sdo_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_cs_n && !$stable(spi_sdo)) |-> !spi_sclk);

    // R2: clock pulses low only inside a frame
    a_r2_sclk_low_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_sclk |-> !spi_cs_n);

    // R3: idle lines are high
    a_r3_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> (spi_sclk && spi_sdo));

    // R9: frames happen only during a run
    a_r9_frame_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done comes with busy low
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9: a run ends only through done
    a_r9_busy_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind panel_init_seq panel_init_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .spi_sclk (spi_sclk),
    .spi_sdo  (spi_sdo),
    .busy     (busy),
    .done     (done)
);

// File: tb/tb_panel_init_seq.sv
// Scoreboard bench: drivers queue the expected frames and gaps, and a monitor
// decodes the serial lines and compares them against the queue.
module tb_panel_init_seq;
    localparam int CLK_PER_US = 4;
    localparam int SCLK_HALF  = 2;
    localparam int GAP_US     = 3;
    localparam int LOW_EXP    = 48 * SCLK_HALF + GAP_US * CLK_PER_US;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_pwr = 1'b0, start_on = 1'b0, start_off = 1'b0;
    logic spi_cs_n, spi_sclk, spi_sdo, busy, done;

    int checks = 0;
    int fails  = 0;

    logic [23:0] fq[$];
    int          gq[$];
    string       tq[$];
    int          prev_dly = 0;

    int          high_cnt = 0, low_cnt = 0, slow = 0, nbits = 0;
    int          frames = 0, done_cnt = 0;
    logic [23:0] shreg = '0;
    logic        prev_cs = 1'b1, prev_sclk = 1'b1;

    always #5 clk = ~clk;

    panel_init_seq #(
        .CLK_PER_US (CLK_PER_US),
        .SCLK_HALF  (SCLK_HALF),
        .GAP_US     (GAP_US)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_pwr (start_pwr),
        .start_on  (start_on),
        .start_off (start_off),
        .spi_cs_n  (spi_cs_n),
        .spi_sclk  (spi_sclk),
        .spi_sdo   (spi_sdo),
        .busy      (busy),
        .done      (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push_entry(input logic [15:0] ix, input logic [15:0] v,
                              input int d, input bit first, input string tag);
        fq.push_back({8'h74, ix}); gq.push_back(first ? 0 : 2 + prev_dly * CLK_PER_US); tq.push_back(tag);
        fq.push_back({8'h76, v});  gq.push_back(2);                                     tq.push_back(tag);
        prev_dly = d;
    endtask

    task automatic push_on(input bit first, input string tag);
        push_entry(16'h0007, 16'h0001, 150, first, tag);
        push_entry(16'h0007, 16'h0101, 150, 1'b0, tag);
        push_entry(16'h0007, 16'h0103, 0, 1'b0, tag);
    endtask

    task automatic push_off(input string tag);
        push_entry(16'h000B, 16'h33E1, 0, 1'b1, tag);
        push_entry(16'h0007, 16'h0102, 150, 1'b0, tag);
        push_entry(16'h0007, 16'h0100, 150, 1'b0, tag);
        push_entry(16'h0012, 16'h0000, 0, 1'b0, tag);
        push_entry(16'h0010, 16'h0000, 0, 1'b0, tag);
    endtask

    task automatic push_pwr(input string tag);
        push_entry(16'h0011, 16'h2000, 0, 1'b1, tag);
        push_entry(16'h0013, 16'h4000, 5, 1'b0, tag);
        push_entry(16'h0010, 16'h3100, 20, 1'b0, tag);
        push_entry(16'h0008, 16'h0005, 0, 1'b0, tag);
        push_on(1'b0, tag);
    endtask

    // Pulse the chosen starts for one cycle; R9: busy follows in the next cycle.
    task automatic pulse(input bit p, input bit on, input bit off, input bit check_busy);
        @(negedge clk);
        start_pwr = p; start_on = on; start_off = off;
        @(negedge clk);
        start_pwr = 1'b0; start_on = 1'b0; start_off = 1'b0;
        if (check_busy) chk(busy === 1'b1, "R9", "busy after start", busy, 1);
    endtask

    // Wait for done; R9: one cycle only, with busy low.
    task automatic wait_done(input string tag);
        int n;
        n = 0;
        while (done !== 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done === 1'b1, "R9", "done seen", done, 1);
        chk(busy === 1'b0, "R9", "busy low with done", busy, 0);
        @(negedge clk);
        chk(done === 1'b0, "R9", "done single cycle", done, 0);
        chk(fq.size() == 0, tag, "frames left in queue", fq.size(), 0);
    endtask

    // Monitor: decode frames, check widths and gaps, compare with the scoreboard.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cs   = 1'b1;
            prev_sclk = 1'b1;
        end else begin
            if (prev_cs && !spi_cs_n) begin
                if (fq.size() == 0)
                    chk(1'b0, "R8", "frame with nothing expected", 1, 0);
                else if (gq[0] != 0)
                    chk(high_cnt == gq[0], "R4", "cs high cycles", high_cnt, gq[0]);
                shreg = '0; nbits = 0; low_cnt = 0; slow = 0;
            end
            if (!spi_cs_n) begin
                low_cnt++;
                if (!spi_sclk) slow++;
                if (!prev_sclk && spi_sclk) begin
                    shreg = {shreg[22:0], spi_sdo};
                    nbits++;
                    chk(slow == SCLK_HALF, "R2", "sclk low phase", slow, SCLK_HALF);
                    slow = 0;
                end
            end
            if (!prev_cs && spi_cs_n) begin
                frames++;
                chk(spi_sclk && spi_sdo, "R3", "lines high after frame", {spi_sclk, spi_sdo}, 3);
                if (fq.size() != 0) begin
                    logic [23:0] ef;
                    string       et;
                    ef = fq.pop_front();
                    void'(gq.pop_front());
                    et = tq.pop_front();
                    chk(shreg == ef, et, "frame content", shreg, ef);
                    chk(nbits == 24, "R1", "bits per frame", nbits, 24);
                    chk(low_cnt == LOW_EXP, "R3", "cs low cycles", low_cnt, LOW_EXP);
                end
                high_cnt = 0;
            end
            if (spi_cs_n) high_cnt++;
            if (done) done_cnt++;
            prev_cs   = spi_cs_n;
            prev_sclk = spi_sclk;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int f0, d0;
        // R11: reset state
        repeat (4) @(negedge clk);
        chk({spi_cs_n, spi_sclk, spi_sdo} === 3'b111, "R11", "lines in reset", {spi_cs_n, spi_sclk, spi_sdo}, 7);
        chk({busy, done} === 2'b00, "R11", "flags in reset", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({spi_cs_n, spi_sclk, spi_sdo, busy, done} === 5'b11100, "R11", "after reset",
            {spi_cs_n, spi_sclk, spi_sdo, busy, done}, 5'b11100);

        // R5 with R1, R2, R3, R4: panel enable run
        push_on(1'b1, "R5");
        pulse(1'b0, 1'b1, 1'b0, 1'b1);
        wait_done("R5");

        // R6 and R8: panel disable, with starts made during the run
        push_off("R6");
        f0 = frames; d0 = done_cnt;
        pulse(1'b0, 1'b0, 1'b1, 1'b1);
        repeat (60) @(negedge clk);
        pulse(1'b1, 1'b0, 1'b0, 1'b0);
        repeat (700) @(negedge clk);
        pulse(1'b0, 1'b1, 1'b1, 1'b0);
        wait_done("R6");
        repeat (300) @(negedge clk);
        chk(frames - f0 == 10, "R8", "frames in run", frames - f0, 10);
        chk(done_cnt - d0 == 1, "R8", "done count", done_cnt - d0, 1);
        chk(busy === 1'b0, "R8", "idle after run", busy, 0);

        // R7: power-up falls through into panel enable with one done
        push_pwr("R7");
        d0 = done_cnt;
        pulse(1'b1, 1'b0, 1'b0, 1'b1);
        wait_done("R7");
        repeat (50) @(negedge clk);
        chk(done_cnt - d0 == 1, "R7", "single done", done_cnt - d0, 1);

        // R10: simultaneous starts
        push_pwr("R10");
        pulse(1'b1, 1'b1, 1'b1, 1'b1);
        wait_done("R10");
        push_on(1'b1, "R10");
        pulse(1'b0, 1'b1, 1'b1, 1'b1);
        wait_done("R10");

        repeat (20) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule